// File: doc/BRIEF.md
# Microcontroller Reset Supervisor with Watchdog Pulse Train

This block holds a microcontroller in reset while its supply is unhealthy and watches a software strobe once the supply is good. Two synchronous comparator flags describe the supply: one reports that the rail has climbed past the upper trip point and the other reports that it has sagged under the lower trip point. The block keeps its own supply-good state with hysteresis between them. The active-low reset output is held low while the supply is bad. It stays low for one programmed interval after recovery and is then released on a clock edge.

After release, software must produce a falling edge on the strobe input within each interval. If it stops, the block drives a square wave on the reset output: low for one interval, then high for one interval, again and again. The train ends at the next valid falling edge. The same tick count, `INTERVAL`, sets the power-up delay, the watchdog window and both halves of the train. The strobe passes through a two-flop synchroniser. A low level only counts once it has lasted `MIN_LOW` clock cycles, so glitches are ignored.

The state machine has five states. ST_HOLD covers the bad supply. ST_POR is the power-up delay. ST_WATCH is the open window with reset released. ST_TRAIN_LO and ST_TRAIN_HI are the two halves of the train. The transitions are:
- hold-to-por: the supply becomes good.
- por-to-watch: the delay expires.
- watch-restart: a strobe arrives in the window.
- watch-to-train: the window expires.
- train-flip: either train half expires.
- train-exit: a strobe arrives during the train and returns the block to ST_WATCH.
- any-to-hold: the supply goes bad, from any state.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it with no supply-good event, `cpu_rst_n` is 0.
- R2: The supply-good state sets when `above_hi`=1, clears when `below_lo`=1, and keeps its value when both are 0. When both are 1, `below_lo` wins.
- R3: Reset is released on the (INTERVAL+2)th rising edge counted from the first edge that samples `above_hi`=1 while the supply state is bad.
- R4: From any state, `below_lo`=1 drives `cpu_rst_n` low on the second rising edge after it is sampled. This aborts a running power-up delay, window or train.
- R5: After release, if no strobe arrives, `cpu_rst_n` stays high for exactly INTERVAL cycles and then enters the train.
- R6: In the train, `cpu_rst_n` alternates between exactly INTERVAL cycles low and INTERVAL cycles high for as long as no strobe arrives.
- R7: A strobe is recognised only when `wd_strobe` has been low for MIN_LOW consecutive sampled cycles. Shorter lows, rising edges and a held low level give no further strobe.
- R8: A strobe during the window restarts it. When `wd_strobe` falls at edge a, the train starts at edge a+MIN_LOW+1+INTERVAL.
- R9: A strobe during the train releases reset at edge a+MIN_LOW+1 and opens a full INTERVAL window.
- R10: Strobes have no effect while the supply is bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| above_hi | input | 1 | Supply has risen past the upper trip point |
| below_lo | input | 1 | Supply has fallen under the lower trip point |
| wd_strobe | input | 1 | Asynchronous software strobe; a falling edge services the watchdog |
| cpu_rst_n | output | 1 | Active-low reset to the microcontroller |

## Verification
Assertions check the following on every cycle:
- A bad supply state always pulls reset low on the next cycle.
- Every rise and fall of reset has a timer expiry, a strobe or a supply loss behind it.
- The filter never recognises two strobes on consecutive cycles.
- An expired timer stays expired until it is reloaded.

Only the bench scenarios can show the exact widths: the power-up delay, the window, each half of the train, and the cycle counts from a strobe edge to the reset response. The same holds for the boundary at MIN_LOW-1 versus MIN_LOW low cycles, and for the hysteresis hold when both flags are quiet.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_POR,
        ST_WATCH,
        ST_TRAIN_LO,
        ST_TRAIN_HI
    } sup_state_t;
endpackage

// File: rtl/sup_level_hyst.sv
module sup_level_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic good
);
    // Lower trip has priority: a sagging rail is never reported good.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        good <= 1'b0;
        else if (below_lo) good <= 1'b0;
        else if (above_hi) good <= 1'b1;
    end
endmodule

// File: rtl/wd_strobe_filter.sv
module wd_strobe_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_strobe,
    output logic kick
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] FULL    = CW'(MIN_LOW);
    localparam logic [CW-1:0] KICK_AT = CW'(MIN_LOW - 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= 1'b1;
            sync_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            meta_q <= wd_strobe;
            sync_q <= meta_q;
            if (sync_q)               low_cnt <= '0;
            else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
        end
    end

    // One kick per low phase, after MIN_LOW low samples.
    assign kick = !sync_q && (low_cnt == KICK_AT);

    AST_SINGLE_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick); // R7
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LAST;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_EXPIRY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R6
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int INTERVAL = 40,
    parameter int MIN_LOW  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    input  logic wd_strobe,
    output logic cpu_rst_n
);
    import sup_pkg::*;

    sup_state_t state_q, state_d;
    logic       good;
    logic       kick;
    logic       tmr_done;
    logic       tmr_load;

    sup_level_hyst u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_hi (above_hi),
        .below_lo (below_lo),
        .good     (good)
    );

    wd_strobe_filter #(.MIN_LOW(MIN_LOW)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_strobe (wd_strobe),
        .kick      (kick)
    );

    interval_timer #(.TICKS(INTERVAL)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!good) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:     state_d = ST_POR;
                ST_POR:      if (tmr_done) state_d = ST_WATCH;
                ST_WATCH:    if (!kick && tmr_done) state_d = ST_TRAIN_LO;
                ST_TRAIN_LO: if (kick) state_d = ST_WATCH;
                             else if (tmr_done) state_d = ST_TRAIN_HI;
                ST_TRAIN_HI: if (kick) state_d = ST_WATCH;
                             else if (tmr_done) state_d = ST_TRAIN_LO;
                default:     state_d = ST_HOLD;
            endcase
        end
    end

    // Every state change, and a strobe inside the window, starts a fresh interval.
    assign tmr_load = (state_d != state_q) ||
                      (state_q == ST_WATCH && good && kick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Output decode from the registered state only.
    always_comb begin
        unique case (state_q)
            ST_WATCH, ST_TRAIN_HI: cpu_rst_n = 1'b1;
            default:               cpu_rst_n = 1'b0;
        endcase
    end

    AST_BAD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> !cpu_rst_n); // R4
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(tmr_done || kick)); // R9
    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_n) |-> $past(tmr_done || !good)); // R5
    AST_POR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_rst_n) && $past(state_q) == ST_POR) |-> $past(tmr_done)); // R3
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int INTERVAL   = 40;
    localparam int MIN_LOW    = 4;
    localparam int LIMIT      = 10 * INTERVAL;
    localparam int WD_CYCLES  = 20000;

    // Pulse-width table: low cycles applied at train start, and whether it must release reset.
    localparam int NV = 5;
    localparam int PULSE_W [NV] = '{1, 2, MIN_LOW - 1, MIN_LOW, MIN_LOW + 1};
    localparam bit PULSE_OK[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_hi = 1'b0;
    logic below_lo = 1'b0;
    logic wd_strobe = 1'b1;
    logic cpu_rst_n;

    int errors = 0;
    int checks = 0;

    rst_supervisor #(.INTERVAL(INTERVAL), .MIN_LOW(MIN_LOW)) i_rst_supervisor (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_hi  (above_hi),
        .below_lo  (below_lo),
        .wd_strobe (wd_strobe),
        .cpu_rst_n (cpu_rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count negedges until the output shows lvl.
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cpu_rst_n !== lvl && n < LIMIT);
    endtask

    // Count consecutive samples (from the current one) at lvl.
    task automatic measure(input logic lvl, output int n);
        n = 0;
        while (cpu_rst_n === lvl && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int w);
        wd_strobe = 1'b0;
        repeat (w) @(negedge clk);
        wd_strobe = 1'b1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int highs;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(cpu_rst_n === 1'b0, "R1 low during block reset", cpu_rst_n, 0);
        rst_n = 1'b1;
        highs = 0;
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            @(negedge clk);
            if (cpu_rst_n !== 1'b0) highs++;
        end
        check(highs == 0, "R1 low with no supply-good event", highs, 0);

        // R3: power-up delay
        above_hi = 1'b1;
        wait_level(1'b1, n);
        check(n == INTERVAL + 2, "R3 power-up release edge", n, INTERVAL + 2);
        // R5: unserviced window
        measure(1'b1, n);
        check(n == INTERVAL, "R5 window width", n, INTERVAL);
        // R6: train halves
        measure(1'b0, n);
        check(n == INTERVAL, "R6 train low width 1", n, INTERVAL);
        measure(1'b1, n);
        check(n == INTERVAL, "R6 train high width", n, INTERVAL);
        measure(1'b0, n);
        check(n == INTERVAL, "R6 train low width 2", n, INTERVAL);

        // R7 table: pulse widths around MIN_LOW applied at the start of a train low half
        for (int v = 0; v < NV; v++) begin
            while (cpu_rst_n === 1'b0) @(negedge clk);
            while (cpu_rst_n === 1'b1) @(negedge clk);
            pulse(PULSE_W[v]);
            repeat (MIN_LOW + 3) @(negedge clk);
            check(cpu_rst_n === PULSE_OK[v], $sformatf("R7 pulse width %0d", PULSE_W[v]),
                  cpu_rst_n, PULSE_OK[v]);
        end

        // R8: a strobe in the window restarts it (the last table entry left the window open)
        wd_strobe = 1'b0;
        wait_level(1'b0, n);
        check(n == INTERVAL + MIN_LOW + 2, "R8 window restart to train", n, INTERVAL + MIN_LOW + 2);
        // R7: a rising edge does not service the watchdog
        wd_strobe = 1'b1;
        measure(1'b0, n);
        check(n == INTERVAL, "R7 rising edge ignored in train", n, INTERVAL);

        // R9: a strobe ends the train
        while (cpu_rst_n === 1'b1) @(negedge clk);
        wd_strobe = 1'b0;
        wait_level(1'b1, n);
        check(n == MIN_LOW + 2, "R9 train exit latency", n, MIN_LOW + 2);
        // R7: a held low gives no second strobe; R9: full window
        measure(1'b1, n);
        check(n == INTERVAL, "R9 window after exit with held low", n, INTERVAL);
        wd_strobe = 1'b1;

        // R4: supply loss aborts the window
        @(negedge clk);
        pulse(MIN_LOW + 1);
        wait_level(1'b1, n);
        check(cpu_rst_n === 1'b1, "R9 re-entered window", cpu_rst_n, 1);
        above_hi = 1'b0;
        below_lo = 1'b1;
        wait_level(1'b0, n);
        check(n == 2, "R4 supply loss in window", n, 2);
        below_lo = 1'b0;
        // R10 and R2: strobes ignored and state held while supply bad and flags quiet
        highs = 0;
        for (int k = 0; k < 3; k++) begin
            wd_strobe = 1'b0;
            for (int i = 0; i < MIN_LOW + 2; i++) begin
                @(negedge clk);
                if (cpu_rst_n !== 1'b0) highs++;
            end
            wd_strobe = 1'b1;
            for (int i = 0; i < INTERVAL; i++) begin
                @(negedge clk);
                if (cpu_rst_n !== 1'b0) highs++;
            end
        end
        check(highs == 0, "R10 strobes ignored while supply bad (R2 hold)", highs, 0);

        // R3 again, then R2: good is held when both flags drop
        above_hi = 1'b1;
        wait_level(1'b1, n);
        check(n == INTERVAL + 2, "R3 release after recovery", n, INTERVAL + 2);
        above_hi = 1'b0;
        measure(1'b1, n);
        check(n == INTERVAL, "R2 good held with flags quiet", n, INTERVAL);
        measure(1'b0, n);
        check(n == INTERVAL, "R6 train continues with flags quiet", n, INTERVAL);

        // R4: supply loss during the train high half
        below_lo = 1'b1;
        wait_level(1'b0, n);
        check(n == 2, "R4 supply loss in train", n, 2);
        below_lo = 1'b0;
        above_hi = 1'b1;
        wait_level(1'b1, n);
        check(n == INTERVAL + 2, "R3 release after train abort", n, INTERVAL + 2);

        // R8: regular strobes keep reset released
        highs = 0;
        for (int k = 0; k < 8; k++) begin
            wd_strobe = 1'b0;
            for (int i = 0; i < INTERVAL / 2; i++) begin
                if (i == MIN_LOW + 1) wd_strobe = 1'b1;
                @(negedge clk);
                if (cpu_rst_n !== 1'b1) highs++;
            end
        end
        check(highs == 0, "R8 periodic strobes keep reset high", highs, 0);

        // R2: both flags set, the lower trip wins
        below_lo = 1'b1;
        wait_level(1'b0, n);
        check(n == 2, "R2 lower trip priority", n, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule